// File: doc/BRIEF.md
# Three-Wire Serial Word-Store Slave

This block is the device side of a small word-organised nonvolatile store reached over a three-wire serial link. The link has a select line, a shift clock, a data input and a data output. The host raises the select line. It then clocks in a start bit, a two-bit operation field and a word address, and the block decodes one of seven instructions. Reads are served from a register-file array. Programming instructions run a timed busy cycle, and they are accepted only while a sticky programming-enable latch is set.

All three link inputs are brought into the system clock domain through a synchronizer. Shift-clock rising edges are found there by an edge detector. The data output comes with an output-enable, so a pad can tri-state it. When the select line is raised again while a program cycle is running, the output shows ready/busy status in place of any new instruction.

Top module: `w3_nvm_slave`

## Requirements
- R1: After reset the output-enable is low and the programming-enable latch is clear, so a write sent before any enable instruction leaves the addressed word unchanged.
- R2: A frame opens when the select line goes high. Zeros seen before the first 1 are skipped. That 1 is the start bit, and it is followed by a 2-bit operation field and an ADDR_W-bit address, each sent most significant bit first.
- R3: Operation 2'b10 reads. After the last address bit the output is enabled and drives one 0. Each later shift-clock rising edge then presents the next bit of the 16-bit word, most significant bit first. This works whether the latch is set or clear.
- R4: Operation 2'b01 writes. The 16 data bits that follow the address, most significant first, replace the word. No earlier erase is needed.
- R5: Operation 2'b11 erases. It sets the addressed word to 16'hFFFF.
- R6: Operation 2'b00 picks a special instruction from the two top address bits: 2'b11 sets the latch and 2'b00 clears it. The four low address bits are ignored. While the latch is clear, erase, write, erase-all and write-all change no word and start no program cycle.
- R7: Under operation 2'b00, top address bits 2'b10 set every word to 16'hFFFF. Bits 2'b01 take 16 data bits and write them to every word.
- R8: Every accepted program instruction starts a busy cycle of PROG_CYCLES system clocks, once its last bit has arrived. While that cycle runs, every instruction is ignored.
- R9: The output-enable is low while the select line is low. If the select line is lowered and raised again during a busy cycle, the output is enabled and shows 0 while busy and 1 once done. If it is raised after the cycle has ended, the output stays disabled.
- R10: Lowering the select line part-way through a frame abandons it. No word changes and no busy cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Link select, high for the length of a frame |
| sclk_i | input | 1 | Link shift clock, sampled on its rising edge |
| sdi_i | input | 1 | Link serial data in |
| sdo_o | output | 1 | Link serial data out |
| sdo_oe_o | output | 1 | Output-enable for sdo_o, low means tri-state |

## Verification
The bench goes after the leading dummy zero of a read. A design that skips it shifts the word one place and loses the last bit. It tests writes and erases sent while the latch is clear, and again while a busy cycle runs. A design that leaks either case corrupts a word that is read back later. It checks the status window three ways: status must be 0 when the select line is raised early, 1 after the cycle completes, and absent when the select line is raised late. A design that gets this wrong drives a stale or spurious ready/busy level. A frame cut off half-way through its data must leave the word intact. A design that writes early would store a partly shifted value.

// File: rtl/w3_nvm_pkg.sv
package w3_nvm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_HUNT, ST_CMD, ST_DATA, ST_READ, ST_STAT, ST_DONE
   } fsm_t;

   localparam logic [1:0] OP_SPECIAL = 2'b00;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;
   localparam logic [1:0] OP_ERASE   = 2'b11;

   localparam logic [1:0] SP_LOCK    = 2'b00;
   localparam logic [1:0] SP_FILL    = 2'b01;
   localparam logic [1:0] SP_WIPE    = 2'b10;
   localparam logic [1:0] SP_UNLOCK  = 2'b11;
endpackage

// File: rtl/w3_nvm_sync.sv
module w3_nvm_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("w3_nvm_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/w3_nvm_array.sv
module w3_nvm_array #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          we_one,
   input  logic          we_all,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] words [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (we_all || (we_one && waddr == AW'(w))) words[w] <= wdata;
      end
   end

   assign rdata = words[raddr];
endmodule

// File: rtl/w3_nvm_timer.sv
module w3_nvm_timer #(
   parameter int CYC = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYC + 1);

   if (CYC < 1) begin : g_bad_cyc
      $error("w3_nvm_timer: CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= CW'(CYC);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/w3_nvm_slave.sv
module w3_nvm_slave #(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int PROG_CYCLES = 400,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic sclk_i,
   input  logic sdi_i,
   output logic sdo_o,
   output logic sdo_oe_o
);
   import w3_nvm_pkg::*;

   localparam int CMD_W = 2 + ADDR_W;
   localparam int MAXB  = (DATA_W > CMD_W) ? DATA_W : CMD_W;
   localparam int CNT_W = $clog2(MAXB) + 1;

   if (ADDR_W < 2) begin : g_bad_aw
      $error("w3_nvm_slave: ADDR_W must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_dw
      $error("w3_nvm_slave: DATA_W must be at least 2");
   end

   // synchronized link inputs and shift-clock edge
   logic [2:0] lnk_s;
   logic       cs_s, sk_s, di_s, sk_last, sk_rise;

   w3_nvm_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d({sel_i, sclk_i, sdi_i}), .q(lnk_s)
   );
   assign {cs_s, sk_s, di_s} = lnk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sk_last <= 1'b0;
      else        sk_last <= sk_s;
   end
   assign sk_rise = sk_s & ~sk_last;

   // state
   fsm_t              state, st_n;
   logic [CMD_W-2:0]  cmd_q, cmd_n;
   logic [CMD_W-1:0]  cmd_sh;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic [DATA_W-1:0] dat_q, dat_n, dat_sh;
   logic              all_q, all_n, prog_en, en_n, sdo_q, sdo_n;

   // array and timer interface
   logic              we_one, we_all, prog_start, rd_load, busy;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [DATA_W-1:0] wdata, rdata;
   logic [1:0]        op, sp;

   assign cmd_sh = {cmd_q, di_s};
   assign dat_sh = {dat_q[DATA_W-2:0], di_s};
   assign raddr  = cmd_sh[ADDR_W-1:0];
   assign op     = cmd_sh[CMD_W-1 -: 2];
   assign sp     = cmd_sh[ADDR_W-1 -: 2];

   w3_nvm_array #(.AW(ADDR_W), .DW(DATA_W)) array_i (
      .clk(clk), .we_one(we_one), .we_all(we_all), .waddr(waddr),
      .wdata(wdata), .raddr(raddr), .rdata(rdata)
   );

   w3_nvm_timer #(.CYC(PROG_CYCLES)) timer_i (
      .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
   );

   always_comb begin
      st_n       = state;
      cmd_n      = cmd_q;
      cnt_n      = cnt_q;
      dat_n      = dat_q;
      all_n      = all_q;
      en_n       = prog_en;
      sdo_n      = sdo_q;
      we_one     = 1'b0;
      we_all     = 1'b0;
      prog_start = 1'b0;
      rd_load    = 1'b0;
      wdata      = dat_sh;
      waddr      = cmd_q[ADDR_W-1:0];
      if (!cs_s) begin
         st_n = ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE: st_n = busy ? ST_STAT : ST_HUNT;
            ST_HUNT: if (sk_rise && di_s) begin
               st_n  = ST_CMD;
               cnt_n = '0;
            end
            ST_CMD: if (sk_rise) begin
               cmd_n = cmd_sh[CMD_W-2:0];
               cnt_n = cnt_q + 1'b1;
               if (cnt_q == CNT_W'(CMD_W - 1)) begin
                  st_n  = ST_DONE;
                  waddr = cmd_sh[ADDR_W-1:0];
                  cnt_n = '0;
                  unique case (op)
                     OP_READ: begin
                        st_n    = ST_READ;
                        rd_load = 1'b1;
                        sdo_n   = 1'b0;
                        dat_n   = rdata;
                     end
                     OP_WRITE: if (prog_en) begin
                        st_n  = ST_DATA;
                        all_n = 1'b0;
                     end
                     OP_ERASE: if (prog_en) begin
                        wdata      = '1;
                        we_one     = 1'b1;
                        prog_start = 1'b1;
                     end
                     default: begin
                        unique case (sp)
                           SP_UNLOCK: en_n = 1'b1;
                           SP_LOCK:   en_n = 1'b0;
                           SP_WIPE: if (prog_en) begin
                              wdata      = '1;
                              we_all     = 1'b1;
                              prog_start = 1'b1;
                           end
                           default: if (prog_en) begin
                              st_n  = ST_DATA;
                              all_n = 1'b1;
                           end
                        endcase
                     end
                  endcase
               end
            end
            ST_DATA: if (sk_rise) begin
               dat_n = dat_sh;
               cnt_n = cnt_q + 1'b1;
               if (cnt_q == CNT_W'(DATA_W - 1)) begin
                  we_one     = ~all_q;
                  we_all     = all_q;
                  prog_start = 1'b1;
                  st_n       = ST_DONE;
               end
            end
            ST_READ: if (sk_rise) begin
               sdo_n = dat_q[DATA_W-1];
               dat_n = {dat_q[DATA_W-2:0], 1'b0};
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cmd_q   <= '0;
         cnt_q   <= '0;
         dat_q   <= '0;
         all_q   <= 1'b0;
         prog_en <= 1'b0;
         sdo_q   <= 1'b0;
      end else begin
         state   <= st_n;
         cmd_q   <= cmd_n;
         cnt_q   <= cnt_n;
         dat_q   <= dat_n;
         all_q   <= all_n;
         prog_en <= en_n;
         sdo_q   <= sdo_n;
      end
   end

   assign sdo_oe_o = (state == ST_READ) || (state == ST_STAT);
   assign sdo_o    = (state == ST_STAT) ? ~busy : sdo_q;
endmodule

// File: rtl/w3_nvm_chk.sv
module w3_nvm_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic sdo_o,
   input logic sdo_oe_o,
   input logic prog_start,
   input logic prog_en,
   input logic busy,
   input logic rd_load
);
   a_r9_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !sdo_oe_o);

   a_r3_dummy_zero_first: assert property (@(posedge clk) disable iff (!rst_n)
      rd_load |=> (sdo_oe_o && !sdo_o));

   a_r6_program_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> prog_en);

   a_r8_start_makes_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |=> busy);

   a_r8_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |-> !busy);
endmodule

bind w3_nvm_slave w3_nvm_chk chk_i (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
   .prog_start(prog_start), .prog_en(prog_en), .busy(busy), .rd_load(rd_load)
);

// File: tb/w3_nvm_slave_tb_top.sv
`timescale 1ns/1ps
module w3_nvm_slave_tb_top;
   localparam int PROG = 400;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
   logic sdo, oe;
   int   total = 0, bad = 0;

   logic [15:0] mem_m [64];
   bit          en_m;

   always #5 clk = ~clk;

   w3_nvm_slave #(.PROG_CYCLES(PROG)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_i(cs), .sclk_i(sk), .sdi_i(di),
      .sdo_o(sdo), .sdo_oe_o(oe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic clk_bit(input logic b, output logic seen);
      sk = 1'b0; di = b; tick(HALF);
      seen = sdo;
      sk = 1'b1; tick(HALF);
   endtask

   task automatic select();
      sk = 1'b0; cs = 1'b1; tick(6);
   endtask

   task automatic deselect();
      sk = 1'b0; tick(4); cs = 1'b0; tick(8);
   endtask

   task automatic send_hdr(input logic [1:0] opc, input logic [5:0] a);
      logic x;
      clk_bit(1'b1, x);
      for (int i = 1; i >= 0; i--) clk_bit(opc[i], x);
      for (int i = 5; i >= 0; i--) clk_bit(a[i], x);
   endtask

   task automatic send_word(input logic [15:0] d, input int nbits);
      logic x;
      for (int i = 15; i > 15 - nbits; i--) clk_bit(d[i], x);
   endtask

   function automatic logic [15:0] expect_word(input logic [5:0] a);
      return mem_m[a];
   endfunction

   task automatic do_read(input logic [5:0] a, input int lead, input string req);
      logic [15:0] d;
      logic dm, b, oe_s, x;
      select();
      for (int i = 0; i < lead; i++) clk_bit(1'b0, x);
      send_hdr(2'b10, a);
      clk_bit(1'b0, dm);
      oe_s = oe;
      d = '0;
      for (int i = 0; i < 16; i++) begin
         clk_bit(1'b0, b);
         d = {d[14:0], b};
      end
      deselect();
      check({req, " read oe"}, 32'(oe_s), 32'd1);
      check({req, " dummy zero"}, 32'(dm), 32'd0);
      check({req, " read data"}, 32'(d), 32'(expect_word(a)));
   endtask

   task automatic do_write(input logic [5:0] a, input logic [15:0] d);
      select(); send_hdr(2'b01, a); send_word(d, 16); deselect();
      if (en_m) mem_m[a] = d;
   endtask

   task automatic do_erase(input logic [5:0] a);
      select(); send_hdr(2'b11, a); deselect();
      if (en_m) mem_m[a] = 16'hFFFF;
   endtask

   task automatic do_special(input logic [1:0] sp);
      select(); send_hdr(2'b00, {sp, 4'($urandom)}); deselect();
      if (sp == 2'b11) en_m = 1'b1;
      if (sp == 2'b00) en_m = 1'b0;
      if (sp == 2'b10 && en_m) for (int i = 0; i < 64; i++) mem_m[i] = 16'hFFFF;
   endtask

   task automatic do_fill(input logic [15:0] d);
      select(); send_hdr(2'b00, {2'b01, 4'b0110}); send_word(d, 16); deselect();
      if (en_m) for (int i = 0; i < 64; i++) mem_m[i] = d;
   endtask

   task automatic status(output logic o_oe, output logic o_d);
      select();
      o_oe = oe; o_d = sdo;
   endtask

   task automatic wait_prog();
      tick(PROG + 40);
   endtask

   initial begin : watchdog
      tick(190000);
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic so, sd;
      logic [5:0] a;
      logic [15:0] d;
      int seed_v;
      seed_v = int'($urandom(32'h5EED_0193));
      tick(5);
      check("R1 oe in reset", 32'(oe), 32'd0);
      rst_n = 1'b1; tick(5);
      check("R1 oe after reset", 32'(oe), 32'd0);

      // bring array to a known state
      do_special(2'b11);
      do_special(2'b10); wait_prog();
      // second reset: latch must clear, array keeps contents
      rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
      en_m = 1'b0;
      do_write(6'd5, 16'h1234);
      do_read(6'd5, 0, "R1");

      // R3 read while locked; R2 leading zeros
      do_read(6'd9, 0, "R3");
      do_special(2'b11);
      do_write(6'd9, 16'hC3A5); wait_prog();
      do_read(6'd9, 3, "R2");
      do_write(6'd9, 16'h0F0F); wait_prog();
      do_read(6'd9, 0, "R4");
      do_write(6'd63, 16'h8001); wait_prog();
      do_read(6'd63, 1, "R4");
      do_erase(6'd63); wait_prog();
      do_read(6'd63, 0, "R5");

      // R9 status window and R8 busy length / ignore
      do_write(6'd20, 16'hBEEF);
      status(so, sd);
      check("R9 status oe busy", 32'(so), 32'd1);
      check("R9 status busy value", 32'(sd), 32'd0);
      send_hdr(2'b01, 6'd21); send_word(16'h0000, 16);
      tick(PROG);
      check("R9 status ready value", 32'(sdo), 32'd1);
      check("R9 status oe ready", 32'(oe), 32'd1);
      deselect();
      check("R9 oe off deselected", 32'(oe), 32'd0);
      status(so, sd);
      check("R9 no status after cycle", 32'(so), 32'd0);
      deselect();
      do_read(6'd20, 0, "R8");
      do_read(6'd21, 0, "R8 ignored during busy");
      // instruction sent while busy after cs re-raise
      do_write(6'd30, 16'h5A5A);
      select(); send_hdr(2'b11, 6'd30); deselect();
      wait_prog();
      do_read(6'd30, 0, "R8 erase ignored when busy");

      // R6 locked programming ignored
      do_special(2'b00);
      do_erase(6'd30);
      status(so, sd); deselect();
      check("R6 no cycle when locked", 32'(so), 32'd0);
      do_read(6'd30, 0, "R6");
      do_fill(16'h1111);
      do_read(6'd0, 0, "R6 fill locked");

      // R7 fill and wipe
      do_special(2'b11);
      do_fill(16'hA5C3); wait_prog();
      do_read(6'd0, 0, "R7 fill");
      do_read(6'd63, 0, "R7 fill");
      do_read(6'(($urandom) % 64), 0, "R7 fill");
      do_special(2'b10); wait_prog();
      do_read(6'd17, 0, "R7 wipe");
      do_read(6'd42, 0, "R7 wipe");

      // R10 abort mid data
      do_write(6'd11, 16'h7E81); wait_prog();
      select(); send_hdr(2'b01, 6'd11); send_word(16'h0000, 8); deselect();
      status(so, sd); deselect();
      check("R10 no cycle after abort", 32'(so), 32'd0);
      do_read(6'd11, 0, "R10");

      // constrained random mix
      for (int n = 0; n < 40; n++) begin
         a = 6'($urandom);
         d = 16'($urandom);
         case ($urandom % 6)
            0, 5: do_read(a, int'($urandom % 3), "R3 rand");
            1: begin do_write(a, d); if (en_m) wait_prog(); end
            2: begin do_erase(a); if (en_m) wait_prog(); end
            3: do_special(2'b11);
            default: do_special(2'b00);
         endcase
      end
      for (int i = 0; i < 4; i++) do_read(6'($urandom), 0, "R4 rand final");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule